// File: doc/BRIEF.md
# JTAG Command Sequence Engine

This block is a JTAG master that a processor drives through three 32-bit
registers. Software writes a command code, then the parameters that the
command needs. The block holds a fixed table that gives, for every known
command, the full TMS bit pattern, the length of the sequence and a mask of
the TCK periods whose TDI value is worth keeping. It builds the TDO bit pattern
from the parameter values. It then plays both patterns out on the pins, one
bit per TCK period, with TCK made by dividing the system clock.

While the sequence runs, the block samples TDI on every TCK rising edge and
stores only the bits that the mask selects. When the last period ends, the
stored bits and a status word can be read back through the feedback port.
TMS data never crosses the bus. The example table holds three commands:
a test-logic reset, a 32-bit data-register scan and a 64-bit data-register
scan that takes two parameters.

Top module: `jtag_seq_engine`

## Requirements
- R1: After reset the status word (feedback word 0) reads zero, and TCK, TMS and TDO are all low.
- R2: Command code 1 (test-logic reset) takes no parameter and plays 6 TCK periods with TMS 1,1,1,1,1,0 and TDO low. It captures nothing (count field, status bits 23:16, reads 0).
- R3: Command code 2 (32-bit data-register scan) waits for one parameter write, then plays 37 periods. TMS is 1 in periods 0, 34 and 35 and 0 in the rest. TDO carries parameter bit i in period 3+i, LSB first, and is 0 in the other periods.
- R4: TDI is sampled on each TCK rising edge. Masked samples are stored in order: the first in bit 0 of feedback word 1, the 33rd in bit 0 of word 2, and so on. For code 2 the 32 samples of periods 3..34 fill word 1, and the count field reads 32.
- R5: Command code 3 (64-bit scan) does not start until a second parameter write arrives. It then plays 69 periods with TMS 1 in periods 0, 66 and 67. TDO carries the first parameter in periods 3..34 and the second in periods 35..66. TDI from periods 3..66 fills words 1 and 2, and the count field reads 64.
- R6: One TCK period lasts 2*TCK_HALF system clocks. TMS and TDO change only on the clock edge where TCK falls, so they never change while TCK is high.
- R7: Status bit 0 (busy) is 1 while a sequence plays. A command write while busy is ignored, and the running sequence finishes unchanged.
- R8: Status bit 1 (done) is set when the last period ends and is cleared by any command write that is accepted. It is never 1 while busy is 1.
- R9: A parameter write with no command waiting is ignored, and so is a command write with an unknown code. Neither one makes a TCK edge or changes the captured data.
- R10: TCK stays low whenever no sequence is playing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_wr | input | 1 | Write strobe for the command register |
| prm_wr | input | 1 | Write strobe for the parameter register |
| wr_data | input | 32 | Write data for both registers |
| fb_sel | input | SELW (3) | Feedback word select: 0 status, 1..NWORDS capture words |
| fb_data | output | 32 | Feedback read data |
| jtag_tck | output | 1 | Generated test clock |
| jtag_tms | output | 1 | Test mode select toward the target |
| jtag_tdo | output | 1 | Serial data toward the target |
| jtag_tdi | input | 1 | Serial data returned by the target |

## Verification
The hardest situations to reach from the ports are a command write that lands while a sequence is already playing, and a two-parameter command that has received only its first parameter. The bench reaches both by timing its writes against the busy bit. It sends a reset command partway through a scan and then checks that the period count and the TMS pattern are those of the scan. It holds the second parameter back for many cycles and shows that no TCK edge appears in that time. The bench also acts as a target. It drives a known TDI pattern on every falling TCK and records TMS and TDO on every rising TCK, so that capture alignment is checked bit by bit against period numbers.

// File: rtl/jtag_seq_pkg.sv
package jtag_seq_pkg;

  // Command codes understood by the sequence table
  localparam logic [31:0] CMD_TLR  = 32'h0000_0001;
  localparam logic [31:0] CMD_DR32 = 32'h0000_0002;
  localparam logic [31:0] CMD_DR64 = 32'h0000_0003;

  // Period at which the data-register shift starts (after Select, Capture)
  localparam int SHIFT_OFS = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARGS = 2'd1,
    ST_RUN  = 2'd2
  } ctl_state_t;

endpackage

// File: rtl/jtag_cmd_table.sv
module jtag_cmd_table
  import jtag_seq_pkg::*;
#(
  parameter int SEQ_MAX = 256,
  parameter int LW      = 9
) (
  input  logic [31:0]        code,
  input  logic [31:0]        prm0,
  input  logic [31:0]        prm1,
  output logic               known,
  output logic [1:0]         nprm,
  output logic [LW-1:0]      len,
  output logic [SEQ_MAX-1:0] tms_pat,
  output logic [SEQ_MAX-1:0] tdo_pat,
  output logic [SEQ_MAX-1:0] cap_pat
);

  localparam int DR32_LEN = SHIFT_OFS + 32 + 2;
  localparam int DR64_LEN = SHIFT_OFS + 64 + 2;

  always_comb begin
    known   = 1'b0;
    nprm    = 2'd0;
    len     = '0;
    tms_pat = '0;
    tdo_pat = '0;
    cap_pat = '0;
    case (code)
      CMD_TLR: begin
        known = 1'b1;
        len   = LW'(6);
        for (int i = 0; i < 5; i++) tms_pat[i] = 1'b1;
      end
      CMD_DR32: begin
        known = 1'b1;
        nprm  = 2'd1;
        len   = LW'(DR32_LEN);
        tms_pat[0]                = 1'b1;
        tms_pat[SHIFT_OFS + 31]   = 1'b1;
        tms_pat[SHIFT_OFS + 32]   = 1'b1;
        tdo_pat[SHIFT_OFS +: 32]  = prm0;
        cap_pat[SHIFT_OFS +: 32]  = '1;
      end
      CMD_DR64: begin
        known = 1'b1;
        nprm  = 2'd2;
        len   = LW'(DR64_LEN);
        tms_pat[0]                    = 1'b1;
        tms_pat[SHIFT_OFS + 63]       = 1'b1;
        tms_pat[SHIFT_OFS + 64]       = 1'b1;
        tdo_pat[SHIFT_OFS +: 32]      = prm0;
        tdo_pat[SHIFT_OFS + 32 +: 32] = prm1;
        cap_pat[SHIFT_OFS +: 64]      = '1;
      end
      default: known = 1'b0;
    endcase
  end

endmodule

// File: rtl/jtag_tck_gen.sv
module jtag_tck_gen #(
  parameter int TCK_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tck,
  output logic rise_en,
  output logic fall_en
);

  localparam int CW = $clog2(TCK_HALF + 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          tck_q, tck_n;
  logic          wrap;

  assign wrap    = run && (cnt_q == CW'(TCK_HALF - 1));
  assign rise_en = wrap && !tck_q;
  assign fall_en = wrap && tck_q;
  assign tck     = tck_q;

  always_comb begin
    cnt_n = cnt_q;
    tck_n = tck_q;
    if (!run) begin
      cnt_n = '0;
      tck_n = 1'b0;
    end else if (wrap) begin
      cnt_n = '0;
      tck_n = !tck_q;
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tck_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      tck_q <= tck_n;
    end
  end

endmodule

// File: rtl/jtag_shifter.sv
module jtag_shifter #(
  parameter int SEQ_MAX = 256,
  parameter int CAP_MAX = 134,
  parameter int LW      = 9,
  parameter int CNTW    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [LW-1:0]      len,
  input  logic [SEQ_MAX-1:0] tms_pat,
  input  logic [SEQ_MAX-1:0] tdo_pat,
  input  logic [SEQ_MAX-1:0] cap_pat,
  input  logic               rise_en,
  input  logic               fall_en,
  input  logic               tdi,
  output logic               run,
  output logic               finish,
  output logic               tms,
  output logic               tdo,
  output logic [CAP_MAX-1:0] cap_data,
  output logic [CNTW-1:0]    cap_cnt
);

  logic [SEQ_MAX-1:0] tms_sr, tms_sr_n;
  logic [SEQ_MAX-1:0] tdo_sr, tdo_sr_n;
  logic [SEQ_MAX-1:0] msk_sr, msk_sr_n;
  logic [LW-1:0]      rem_q, rem_n;
  logic               run_q, run_n;
  logic [CAP_MAX-1:0] cap_q, cap_n;
  logic [CNTW-1:0]    cnt_q, cnt_n;
  logic               upd_en;

  assign upd_en   = load || run_q;
  assign run      = run_q;
  assign finish   = run_q && fall_en && (rem_q == '0);
  assign tms      = tms_sr[0];
  assign tdo      = tdo_sr[0];
  assign cap_data = cap_q;
  assign cap_cnt  = cnt_q;

  always_comb begin
    tms_sr_n = tms_sr;
    tdo_sr_n = tdo_sr;
    msk_sr_n = msk_sr;
    rem_n    = rem_q;
    run_n    = run_q;
    cap_n    = cap_q;
    cnt_n    = cnt_q;
    if (load) begin
      tms_sr_n = tms_pat;
      tdo_sr_n = tdo_pat;
      msk_sr_n = cap_pat;
      rem_n    = len - 1'b1;
      run_n    = 1'b1;
      cap_n    = '0;
      cnt_n    = '0;
    end else if (run_q) begin
      if (rise_en && msk_sr[0] && (cnt_q < CNTW'(CAP_MAX))) begin
        cap_n[cnt_q] = tdi;
        cnt_n        = cnt_q + 1'b1;
      end
      if (fall_en) begin
        tms_sr_n = tms_sr >> 1;
        tdo_sr_n = tdo_sr >> 1;
        msk_sr_n = msk_sr >> 1;
        if (rem_q == '0) run_n = 1'b0;
        else             rem_n = rem_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tms_sr <= '0;
      tdo_sr <= '0;
      msk_sr <= '0;
      rem_q  <= '0;
      run_q  <= 1'b0;
      cap_q  <= '0;
      cnt_q  <= '0;
    end else if (upd_en) begin
      tms_sr <= tms_sr_n;
      tdo_sr <= tdo_sr_n;
      msk_sr <= msk_sr_n;
      rem_q  <= rem_n;
      run_q  <= run_n;
      cap_q  <= cap_n;
      cnt_q  <= cnt_n;
    end
  end

endmodule

// File: rtl/jtag_seq_engine.sv
module jtag_seq_engine
  import jtag_seq_pkg::*;
#(
  parameter int SEQ_MAX  = 256,
  parameter int CAP_MAX  = 134,
  parameter int TCK_HALF = 2,
  localparam int NWORDS  = (CAP_MAX + 31) / 32,
  localparam int SELW    = $clog2(NWORDS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_wr,
  input  logic            prm_wr,
  input  logic [31:0]     wr_data,
  input  logic [SELW-1:0] fb_sel,
  output logic [31:0]     fb_data,
  output logic            jtag_tck,
  output logic            jtag_tms,
  output logic            jtag_tdo,
  input  logic            jtag_tdi
);

  localparam int LW   = $clog2(SEQ_MAX + 1);
  localparam int CNTW = $clog2(CAP_MAX + 1);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  ctl_state_t   state_q, state_n;
  logic [31:0]  cmd_q, cmd_n;
  logic [31:0]  prm0_q, prm0_n;
  logic [31:0]  prm1_q, prm1_n;
  logic [1:0]   pcnt_q, pcnt_n;
  logic         done_q, done_n;
  logic         load;
  logic         busy;

  logic               known;
  logic [1:0]         nprm;
  logic [LW-1:0]      len;
  logic [SEQ_MAX-1:0] tms_pat, tdo_pat, cap_pat;

  logic               run, finish, rise_en, fall_en;
  logic [CAP_MAX-1:0] cap_data;
  logic [CNTW-1:0]    cap_cnt;

  assign busy = (state_q == ST_RUN);

  jtag_cmd_table #(.SEQ_MAX(SEQ_MAX), .LW(LW)) u_table (
    .code    (cmd_q),
    .prm0    (prm0_q),
    .prm1    (prm1_q),
    .known   (known),
    .nprm    (nprm),
    .len     (len),
    .tms_pat (tms_pat),
    .tdo_pat (tdo_pat),
    .cap_pat (cap_pat)
  );

  jtag_tck_gen #(.TCK_HALF(TCK_HALF)) u_tck (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .run     (run),
    .tck     (jtag_tck),
    .rise_en (rise_en),
    .fall_en (fall_en)
  );

  jtag_shifter #(
    .SEQ_MAX (SEQ_MAX),
    .CAP_MAX (CAP_MAX),
    .LW      (LW),
    .CNTW    (CNTW)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load     (load),
    .len      (len),
    .tms_pat  (tms_pat),
    .tdo_pat  (tdo_pat),
    .cap_pat  (cap_pat),
    .rise_en  (rise_en),
    .fall_en  (fall_en),
    .tdi      (jtag_tdi),
    .run      (run),
    .finish   (finish),
    .tms      (jtag_tms),
    .tdo      (jtag_tdo),
    .cap_data (cap_data),
    .cap_cnt  (cap_cnt)
  );

  // control: command acceptance, parameter collection, launch
  always_comb begin
    state_n = state_q;
    cmd_n   = cmd_q;
    prm0_n  = prm0_q;
    prm1_n  = prm1_q;
    pcnt_n  = pcnt_q;
    done_n  = done_q;
    load    = 1'b0;
    case (state_q)
      ST_IDLE, ST_ARGS: begin
        if (cmd_wr) begin
          cmd_n   = wr_data;
          pcnt_n  = 2'd0;
          done_n  = 1'b0;
          state_n = ST_ARGS;
        end else if (state_q == ST_ARGS) begin
          if (!known) begin
            state_n = ST_IDLE;
          end else if (pcnt_q == nprm) begin
            load    = 1'b1;
            state_n = ST_RUN;
          end else if (prm_wr) begin
            if (pcnt_q == 2'd0) prm0_n = wr_data;
            else                prm1_n = wr_data;
            pcnt_n = pcnt_q + 1'b1;
          end
        end
      end
      ST_RUN: begin
        if (finish) begin
          state_n = ST_IDLE;
          done_n  = 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= ST_IDLE;
      cmd_q   <= '0;
      prm0_q  <= '0;
      prm1_q  <= '0;
      pcnt_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      cmd_q   <= cmd_n;
      prm0_q  <= prm0_n;
      prm1_q  <= prm1_n;
      pcnt_q  <= pcnt_n;
      done_q  <= done_n;
    end
  end

  // feedback read mux: word 0 status, then capture words
  logic [NWORDS*32-1:0] cap_pad;

  always_comb begin
    cap_pad              = '0;
    cap_pad[CAP_MAX-1:0] = cap_data;
    fb_data              = '0;
    if (fb_sel == '0) begin
      fb_data[0]         = busy;
      fb_data[1]         = done_q;
      fb_data[16 +: CNTW] = cap_cnt;
    end else if (fb_sel <= SELW'(NWORDS)) begin
      fb_data = cap_pad[(int'(fb_sel) - 1) * 32 +: 32];
    end
  end

endmodule

// File: rtl/jtag_seq_checker.sv
module jtag_seq_checker #(
  parameter int CAP_MAX = 134,
  parameter int CNTW    = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_wr,
  input logic            busy,
  input logic            done,
  input logic            tck,
  input logic            tms,
  input logic            tdo,
  input logic [CNTW-1:0] cap_cnt
);

  p_tck_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tck);

  p_pins_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tck |-> ($stable(tms) && $stable(tdo)));

  p_busy_done_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  p_done_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy) |=> !done);

  p_done_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_cap_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cap_cnt <= CNTW'(CAP_MAX)));

endmodule

bind jtag_seq_engine jtag_seq_checker #(
  .CAP_MAX (CAP_MAX),
  .CNTW    (CNTW)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_core_n),
  .cmd_wr  (cmd_wr),
  .busy    (busy),
  .done    (done_q),
  .tck     (jtag_tck),
  .tms     (jtag_tms),
  .tdo     (jtag_tdo),
  .cap_cnt (cap_cnt)
);

// File: tb/jtag_seq_engine_test.sv
`timescale 1ns/1ps
module jtag_seq_engine_test;

  localparam int TCK_HALF = 2;

  logic        clk;
  logic        rst_n;
  logic        cmd_wr;
  logic        prm_wr;
  logic [31:0] wr_data;
  logic [2:0]  fb_sel;
  logic [31:0] fb_data;
  logic        jtag_tck, jtag_tms, jtag_tdo, jtag_tdi;

  int checks = 0;
  int errors = 0;
  int rec_k  = 0;
  int viol   = 0;
  time t_rise0, t_rise1;
  logic [255:0] tms_log, tdo_log;
  logic [255:0] tdi_pat;

  jtag_seq_engine #(.TCK_HALF(TCK_HALF)) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_wr   (cmd_wr),
    .prm_wr   (prm_wr),
    .wr_data  (wr_data),
    .fb_sel   (fb_sel),
    .fb_data  (fb_data),
    .jtag_tck (jtag_tck),
    .jtag_tms (jtag_tms),
    .jtag_tdo (jtag_tdo),
    .jtag_tdi (jtag_tdi)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // target model: record pins on rising TCK
  initial forever begin
    @(posedge jtag_tck);
    if (rec_k == 0) t_rise0 = $time;
    if (rec_k == 1) t_rise1 = $time;
    if (rec_k < 256) begin
      tms_log[rec_k] = jtag_tms;
      tdo_log[rec_k] = jtag_tdo;
    end
    rec_k++;
  end

  // target model: present next TDI bit after falling TCK
  initial forever begin
    @(negedge jtag_tck);
    if (rec_k < 256) jtag_tdi = tdi_pat[rec_k];
  end

  // pins may not move while TCK is high
  initial begin
    logic [1:0] prev;
    prev = 2'b00;
    forever begin
      @(negedge clk);
      if ({jtag_tms, jtag_tdo} != prev && jtag_tck) viol++;
      prev = {jtag_tms, jtag_tdo};
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic write_cmd(input logic [31:0] v);
    @(negedge clk);
    cmd_wr = 1'b1; wr_data = v;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic write_prm(input logic [31:0] v);
    @(negedge clk);
    prm_wr = 1'b1; wr_data = v;
    @(negedge clk);
    prm_wr = 1'b0;
  endtask

  task automatic rd(input int sel, output logic [31:0] v);
    @(negedge clk);
    fb_sel = 3'(sel);
    #0.5;
    v = fb_data;
  endtask

  task automatic clr_log();
    rec_k    = 0;
    tms_log  = '0;
    tdo_log  = '0;
    jtag_tdi = tdi_pat[0];
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(0, s);
      if (s[1]) return;
    end
    chk(1'b0, "R8", "done never set", 0, 1);
  endtask

  task automatic t_reset();
    logic [31:0] s;
    rd(0, s);
    chk(s == 32'h0, "R1", "status after reset", s, 0);
    chk({jtag_tck, jtag_tms, jtag_tdo} == 3'b000, "R1", "pins after reset",
        {jtag_tck, jtag_tms, jtag_tdo}, 0);
  endtask

  task automatic t_tlr();
    logic [31:0] s;
    clr_log();
    write_cmd(32'h1);
    wait_done();
    chk(rec_k == 6, "R2", "period count", rec_k, 6);
    chk(tms_log[5:0] == 6'h1F, "R2", "tms pattern", tms_log[5:0], 6'h1F);
    chk(tdo_log[5:0] == 6'h00, "R2", "tdo pattern", tdo_log[5:0], 0);
    rd(0, s);
    chk(s[23:16] == 8'd0, "R2", "capture count", s[23:16], 0);
    chk(s[1:0] == 2'b10, "R8", "done after end", s[1:0], 2'b10);
    chk(jtag_tck == 1'b0, "R10", "tck idle low", jtag_tck, 0);
  endtask

  task automatic t_dr32();
    logic [31:0]  s;
    logic [31:0]  p;
    logic [127:0] exp;
    p = 32'hA5C3_0F96;
    clr_log();
    write_cmd(32'h2);
    repeat (20) @(negedge clk);
    rd(0, s);
    chk(s[1:0] == 2'b00 && rec_k == 0, "R3", "waits for parameter",
        {s[1:0], 32'(rec_k)}, 0);
    write_prm(p);
    repeat (12) @(negedge clk);
    rd(0, s);
    chk(s[0] == 1'b1, "R7", "busy while shifting", s[0], 1);
    write_cmd(32'h1);
    wait_done();
    chk(rec_k == 37, "R7", "period count unchanged by busy write", rec_k, 37);
    exp = '0; exp[0] = 1'b1; exp[34] = 1'b1; exp[35] = 1'b1;
    chk(tms_log[36:0] == exp[36:0], "R3", "tms pattern", tms_log[36:0], exp[36:0]);
    chk(tdo_log[34:3] == p, "R3", "tdo data", tdo_log[34:3], p);
    chk({tdo_log[36:35], tdo_log[2:0]} == 5'b0, "R3", "tdo outside shift",
        {tdo_log[36:35], tdo_log[2:0]}, 0);
    rd(1, s);
    chk(s == tdi_pat[34:3], "R4", "capture word 1", s, tdi_pat[34:3]);
    rd(0, s);
    chk(s[23:16] == 8'd32, "R4", "capture count", s[23:16], 32);
    chk((t_rise1 - t_rise0) == 4 * 2 * TCK_HALF, "R6", "tck period ns",
        t_rise1 - t_rise0, 4 * 2 * TCK_HALF);
  endtask

  task automatic t_dr64();
    logic [31:0]  s;
    logic [31:0]  p1, p2;
    logic [127:0] exp;
    p1 = 32'h1357_9BDF;
    p2 = 32'hFEDC_0246;
    clr_log();
    write_cmd(32'h3);
    write_prm(p1);
    repeat (20) @(negedge clk);
    rd(0, s);
    chk(s[0] == 1'b0 && rec_k == 0, "R5", "waits for second parameter",
        {s[0], 32'(rec_k)}, 0);
    write_prm(p2);
    wait_done();
    chk(rec_k == 69, "R5", "period count", rec_k, 69);
    exp = '0; exp[0] = 1'b1; exp[66] = 1'b1; exp[67] = 1'b1;
    chk(tms_log[68:0] == exp[68:0], "R5", "tms pattern", tms_log[68:0], exp[68:0]);
    chk(tdo_log[34:3] == p1, "R5", "tdo first parameter", tdo_log[34:3], p1);
    chk(tdo_log[66:35] == p2, "R5", "tdo second parameter", tdo_log[66:35], p2);
    rd(1, s);
    chk(s == tdi_pat[34:3], "R5", "capture word 1", s, tdi_pat[34:3]);
    rd(2, s);
    chk(s == tdi_pat[66:35], "R4", "capture word 2", s, tdi_pat[66:35]);
    rd(0, s);
    chk(s[23:16] == 8'd64, "R5", "capture count", s[23:16], 64);
  endtask

  task automatic t_ignored();
    logic [31:0] s;
    clr_log();
    write_prm(32'hDEAD_BEEF);
    repeat (20) @(negedge clk);
    rd(0, s);
    chk(s[1:0] == 2'b10 && rec_k == 0, "R9", "stray parameter write",
        {s[1:0], 32'(rec_k)}, {2'b10, 32'd0});
    rd(1, s);
    chk(s == tdi_pat[34:3], "R9", "capture kept", s, tdi_pat[34:3]);
    write_cmd(32'h55);
    repeat (20) @(negedge clk);
    rd(0, s);
    chk(s[1:0] == 2'b00 && rec_k == 0, "R9", "unknown code",
        {s[1:0], 32'(rec_k)}, 0);
    chk(s[1] == 1'b0, "R8", "done cleared by command write", s[1], 0);
  endtask

  initial begin
    tdi_pat  = {32'h0F1E_2D3C, 32'h4B5A_6978, 32'h8796_A5B4, 32'hC3D2_E1F0,
                32'h9C8B_7A69, 32'h5847_3625, 32'h6B2F_D01C, 32'h3E94_A7C5};
    rst_n    = 1'b0;
    cmd_wr   = 1'b0;
    prm_wr   = 1'b0;
    wr_data  = '0;
    fb_sel   = '0;
    jtag_tdi = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_tlr();
    t_dr32();
    t_dr64();
    t_ignored();
    chk(viol == 0, "R6", "pin changes while tck high", viol, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule